// File: doc/BRIEF.md
# Sampling strobe edge detector

This block produces the internal sampling strobe for a converter front end from an external strobe pin. It has two modes, chosen by a detect-enable input. In bypass mode the pin drives the output with no logic in the way. In detect mode the pin is first brought into the master clock domain by a synchroniser. A selectable edge of the synchronised signal, rising or falling, is then found, and a pulse one master clock period wide is issued a programmable number of periods (0 to 7) after that edge.

The delay logic is a three-state machine. `ST_IDLE` waits for a qualifying edge. `ST_COUNT` counts down the delay that was loaded at the edge. `ST_FIRE` drives the output pulse for one cycle. The transitions are as follows:

- idle-to-fire: an edge arrives while the delay is 0.
- idle-to-count: an edge arrives while the delay is not 0.
- count-to-count: the count steps down, or a new edge restarts it.
- count-to-fire: the count reaches its last step.
- fire-to-idle: the pulse has been issued.
- fire-to-count and fire-to-fire: an edge arrives during the pulse cycle.
- any-to-idle: detect-enable is low.

Top module: `strobe_edge_detector`

## Requirements
- R1: With `det_en` = 0, `strobe_out` equals `strobe_raw` combinationally in every cycle.
- R2: With `det_en` = 0, `edge_pol` and `dly_sel` have no effect on `strobe_out`.
- R3: With `det_en` = 1, `edge_pol` = 1 qualifies rising edges and `edge_pol` = 0 qualifies falling edges. An edge of the other direction produces no pulse.
- R4: In detect mode, when `strobe_raw` changes to a qualifying level before clock edge n, `strobe_out` is high during the cycle after clock edge n+2+D. D is the unsigned value of the 3-bit `dly_sel` and ranges from 0 to 7. This latency assumes the default two synchroniser stages.
- R5: Each generated pulse is exactly one clock cycle wide, and each qualifying edge yields at most one pulse.
- R6: A qualifying edge that arrives while a pulse is pending cancels the pending pulse and restarts the delay from the new edge, so one pulse results.
- R7: Changes to `dly_sel` or `edge_pol` while a count is pending do not move the pending pulse. They apply from the next detected edge.
- R8: After reset (`rst_n` low), in detect mode, `strobe_out` is low and stays low until a qualifying edge is seen.
- R9: Dropping `det_en` to 0 discards any pending pulse. Re-enabling detect mode with a steady strobe produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_raw | input | 1 | External sampling strobe, asynchronous to clk |
| det_en | input | 1 | 1 = edge detect mode, 0 = bypass |
| edge_pol | input | 1 | 1 = rising edge, 0 = falling edge |
| dly_sel | input | 3 | Delay from detected edge, in clk periods |
| strobe_out | output | 1 | Internal timing strobe |

## Verification
The assertions assume two things about the inputs. First, `edge_pol` is held steady while the strobe is toggling, so two qualifying edges cannot land in adjacent cycles. Second, each strobe level is held for at least one clock period, so the synchroniser sees every level. The stimulus changes settings only at negative clock edges while the strobe is quiet, and holds every strobe level for at least two cycles. A queue of expected pulse cycles is filled from the latency rule as each edge is driven. Any pulse outside that queue, and any queued pulse that is missing, is reported.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    localparam int DLY_W_DEF = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } det_state_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/strobe_edge_find.sv
module strobe_edge_find (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic pol_i,
    output logic hit_o
);
    logic prev_q;
    logic rise_w;
    logic fall_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    always_comb begin
        rise_w = sync_i & ~prev_q;
        fall_w = ~sync_i & prev_q;
        hit_o  = pol_i ? rise_w : fall_w;
    end

    // R3: a qualifying edge leaves the synchronised level equal to the polarity bit
    a_r3_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (sync_i == pol_i));
endmodule

// File: rtl/strobe_delay_fsm.sv
module strobe_delay_fsm
    import strobe_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             hit_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             pulse_o
);
    localparam logic [DLY_W-1:0] ZERO = '0;
    localparam logic [DLY_W-1:0] ONE  = {{(DLY_W-1){1'b0}}, 1'b1};

    det_state_t       st_q, st_n;
    logic [DLY_W-1:0] cnt_q, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= ZERO;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (!en_i) begin
            st_n  = ST_IDLE;
            cnt_n = ZERO;
        end else if (hit_i) begin
            if (dly_i == ZERO) begin
                st_n  = ST_FIRE;
                cnt_n = ZERO;
            end else begin
                st_n  = ST_COUNT;
                cnt_n = dly_i;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_n = ST_IDLE;
                end
                ST_COUNT: begin
                    if (cnt_q == ONE) begin
                        st_n  = ST_FIRE;
                        cnt_n = ZERO;
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
                ST_FIRE: begin
                    st_n = ST_IDLE;
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = ZERO;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_o = (st_q == ST_FIRE);
    end

    a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hit_i && dly_i == ZERO) |=> pulse_o);

    a_r4_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hit_i && dly_i != ZERO) |=> !pulse_o);

    a_r5_one_wide: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        pulse_o |=> !pulse_o);

    a_r7_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT) |-> (cnt_q != ZERO));

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pulse_o);
endmodule

// File: rtl/strobe_edge_detector.sv
module strobe_edge_detector
    import strobe_pkg::*;
#(
    parameter int DLY_W       = DLY_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_raw,
    input  logic             det_en,
    input  logic             edge_pol,
    input  logic [DLY_W-1:0] dly_sel,
    output logic             strobe_out
);
    logic sync_w;
    logic hit_w;
    logic pulse_w;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_raw),
        .sync_o  (sync_w)
    );

    strobe_edge_find u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .pol_i  (edge_pol),
        .hit_o  (hit_w)
    );

    strobe_delay_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (det_en),
        .hit_i   (hit_w),
        .dly_i   (dly_sel),
        .pulse_o (pulse_w)
    );

    // R1: bypass routes the pin straight through
    always_comb begin
        strobe_out = det_en ? pulse_w : strobe_raw;
    end

    // R8: in detect mode nothing leaves the block before an edge was ever found
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && $past(det_en) && !$past(hit_w) && !$past(pulse_w) && !$past(u_fsm.st_q == ST_COUNT))
            |-> !strobe_out);
endmodule

// File: tb/strobe_edge_detector_test.sv
module strobe_edge_detector_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_raw = 1'b0;
    logic       det_en = 1'b0;
    logic       edge_pol = 1'b0;
    logic [2:0] dly_sel = 3'd0;
    logic       strobe_out;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    string cur_req = "R8";
    int    exp_q[$];

    strobe_edge_detector uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_raw (strobe_raw),
        .det_en     (det_en),
        .edge_pol   (edge_pol),
        .dly_sel    (dly_sel),
        .strobe_out (strobe_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare the output with the scoreboard at every falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (!det_en) begin
                if (strobe_out !== strobe_raw) begin
                    errors++;
                    $display("FAIL %s bypass cyc=%0d: got %b expected %b", cur_req, cyc, strobe_out, strobe_raw);
                end
            end else begin
                logic exp_v;
                exp_v = (exp_q.size() > 0) && (exp_q[0] == cyc);
                if (strobe_out !== exp_v) begin
                    errors++;
                    $display("FAIL %s detect cyc=%0d: got %b expected %b", cur_req, cyc, strobe_out, exp_v);
                end
                if (exp_v) void'(exp_q.pop_front());
                else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                    errors++;
                    $display("FAIL %s missed pulse at cyc=%0d: got 0 expected 1", cur_req, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // driver: change the strobe and push the expected pulse cycle
    task automatic drive(input logic v, input bit qual, input bit restart);
        if (restart && exp_q.size() > 0) void'(exp_q.pop_back());
        strobe_raw = v;
        if (qual && det_en) exp_q.push_back(cyc + 3 + int'(dly_sel));
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 leftover pulses: got %0d expected 0", exp_q.size());
        end
        checks++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state in detect mode
        det_en = 1'b1;
        tick(3);
        checks++;
        if (strobe_out !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset: got %b expected 0", strobe_out);
        end
        rst_n = 1'b1;
        tick(2);
        mon_on = 1'b1;
        tick(6);

        // R1 / R2: bypass with settings varied
        det_en = 1'b0;
        cur_req = "R1";
        tick(1);
        for (int i = 0; i < 6; i++) begin
            drive(~strobe_raw, 1'b0, 1'b0);
            tick(i + 1);
        end
        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin
            edge_pol = i[0];
            dly_sel  = 3'(i);
            drive(~strobe_raw, 1'b0, 1'b0);
            tick(2);
        end
        drive(1'b0, 1'b0, 1'b0);
        tick(4);

        // R4 / R3: rising edges with every delay, falling ignored
        edge_pol = 1'b1;
        det_en = 1'b1;
        cur_req = "R8";
        tick(6);
        for (int d = 0; d < 8; d++) begin
            dly_sel = 3'(d);
            cur_req = "R4";
            drive(1'b1, 1'b1, 1'b0);
            tick(12);
            cur_req = "R3";
            drive(1'b0, 1'b0, 1'b0);
            tick(12);
        end

        // R3: falling polarity
        edge_pol = 1'b0;
        for (int k = 0; k < 2; k++) begin
            dly_sel = (k == 0) ? 3'd3 : 3'd5;
            cur_req = "R3";
            drive(1'b1, 1'b0, 1'b0);
            tick(12);
            drive(1'b0, 1'b1, 1'b0);
            tick(12);
        end

        // R6: restart while pending
        edge_pol = 1'b1;
        dly_sel = 3'd7;
        cur_req = "R6";
        drive(1'b1, 1'b1, 1'b0);
        tick(2);
        drive(1'b0, 1'b0, 1'b0);
        tick(2);
        drive(1'b1, 1'b1, 1'b1);
        tick(14);
        drive(1'b0, 1'b0, 1'b0);
        tick(12);

        // R7: settings changed during a pending count
        dly_sel = 3'd6;
        cur_req = "R7";
        drive(1'b1, 1'b1, 1'b0);
        tick(3);
        dly_sel = 3'd1;
        edge_pol = 1'b0;
        tick(12);
        drive(1'b0, 1'b1, 1'b0);
        tick(12);

        // R9: leaving detect mode discards the pending pulse
        edge_pol = 1'b1;
        dly_sel = 3'd7;
        cur_req = "R9";
        drive(1'b1, 1'b1, 1'b0);
        tick(3);
        det_en = 1'b0;
        exp_q.delete();
        tick(2);
        det_en = 1'b1;
        tick(14);

        mon_on = 1'b0;
        finish_run();
    end

endmodule